// File: doc/BRIEF.md
# Memory Card Byte Lane Steering Decoder

This block sits on the card side of a 16-bit removable memory card bus and fans host cycles out to an array of byte-wide storage segments arranged as even/odd pairs. It decodes the two active-low card enables, the output and write strobes, the register (attribute space) select, address bit 0 and the pair-select address bits. From them it produces one chip select per segment, a chip select for the separate attribute store, read and write strobes toward the storage, and the drive enables and lane-swap control for the host data transceivers.

The host data bus is modelled as a read-data vector plus one drive enable per byte lane. An undriven lane reads as zero. All decode results are registered on the card clock. The data path that routes bytes between the host lanes and the segment buses is combinational from those registered controls, so storage read data reaches the host lanes in the same cycle that the storage presents it.

Top module: `lane_steer_top`

## Requirements
- R1: With enable 1 low, enable 2 high and A0 low (even byte access), only the even segment of the selected pair is selected, and a read drives the low lane alone with the even read byte.
- R2: With enable 1 low, enable 2 high and A0 high (odd byte through the low lane), only the odd segment is selected, `laneSwap` is 1, a read places the odd read byte on bits 7:0, and a write copies host bits 7:0 onto the odd write bus.
- R3: With enable 1 high and enable 2 low, the odd segment is selected whatever A0 is, a read drives the high lane (bits 15:8) with the odd byte, and the low lane stays undriven.
- R4: With both enables low and register select high, two segments of the selected pair are selected whatever A0 is, and a read drives even data on bits 7:0 and odd data on bits 15:8.
- R5: With both enables high, no segment or attribute select is asserted and neither lane is driven.
- R6: A lane is driven only when output enable is low and write enable is high. `memOe` follows that read condition and `memWe` follows the write condition (write enable low, output enable high, a card enable low, switch released).
- R7: Segment index is 2*pairSel + 1 for the odd member and 2*pairSel for the even member. No segment outside the selected pair is asserted.
- R8: With register select low, `attrCs` is asserted whenever a card enable is low, no segment is selected, and the high lane is never driven. An odd-address byte read on the low lane returns 8'hFF. Otherwise the attribute byte appears on bits 7:0.
- R9: While `wpSwitch` is 1, `memWe` is 0 and `wpStatus` is 1 one cycle later.
- R10: Exactly one segment select is asserted in a common-space byte access, exactly two in a common-space word access, and none otherwise.
- R11: All select, strobe and lane-enable outputs, `wpStatus` and `laneSwap` change one clock edge after their inputs. `evenWrData` always equals host bits 7:0, and `oddWrData` equals host bits 15:8 when no swap is active.
- R12: While `rstN` is low, every select, strobe, lane enable, `laneSwap` and `wpStatus` is 0, whatever the inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Card clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cardEn1N | input | 1 | Card enable for the low lane, active low |
| cardEn2N | input | 1 | Card enable for the high lane, active low |
| outEnN | input | 1 | Output enable, active low |
| wrEnN | input | 1 | Write enable, active low |
| regSelN | input | 1 | Low selects attribute space |
| addr0 | input | 1 | Byte address bit 0 |
| pairSel | input | 2 | Segment pair select (top address bits) |
| wpSwitch | input | 1 | Write-protect switch, 1 = protected |
| hostWrData | input | 16 | Host write data |
| evenRdData | input | 8 | Read byte from the selected even segment |
| oddRdData | input | 8 | Read byte from the selected odd segment |
| attrRdData | input | 8 | Read byte from attribute memory |
| segCs | output | 8 | Per-segment chip selects, active high |
| attrCs | output | 1 | Attribute memory select |
| memWe | output | 1 | Internal write strobe |
| memOe | output | 1 | Internal read strobe |
| evenWrData | output | 8 | Write byte to the even segment bus |
| oddWrData | output | 8 | Write byte to the odd segment bus |
| hostRdData | output | 16 | Host read data (zero on undriven lanes) |
| loLaneOe | output | 1 | Drive enable for bits 7:0 |
| hiLaneOe | output | 1 | Drive enable for bits 15:8 |
| laneSwap | output | 1 | Odd byte routed through the low lane |
| wpStatus | output | 1 | Write-protect status |

## Verification
Every select, strobe, lane enable, swap and status output is due one clock edge after the inputs that cause it. The bench therefore drives each input pattern on a falling edge, waits for the next rising edge, and samples a quarter period later. The read and write data buses follow combinationally from the registered controls and the storage bytes presented in the same cycle, so they are compared at that same sample point. The sweep covers every combination of enables, strobes, register select, A0, pair select and switch, with storage and host bytes that change with the pattern.

// File: rtl/lane_steer_pkg.sv
package lane_steer_pkg;
  localparam int PAIR_BITS = 2;
  localparam int NUM_SEG   = 2 << PAIR_BITS;
  localparam int BYTE_W    = 8;
  localparam int WORD_W    = 2 * BYTE_W;

  typedef enum logic [1:0] {
    LO_EVEN = 2'd0,
    LO_ODD  = 2'd1,
    LO_ATTR = 2'd2,
    LO_BAD  = 2'd3
  } loSrc_e;

  typedef struct packed {
    logic [NUM_SEG-1:0] segCs;
    logic               attrCs;
    logic               wrStb;
    logic               rdStb;
    logic               loDrive;
    logic               hiDrive;
    loSrc_e             loSrc;
    logic               swapLo;
    logic               wpFlag;
  } strobes_t;
endpackage

// File: rtl/lane_steer_ctrl.sv
module lane_steer_ctrl
  import lane_steer_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cardEn1N,
  input  logic                 cardEn2N,
  input  logic                 outEnN,
  input  logic                 wrEnN,
  input  logic                 regSelN,
  input  logic                 addr0,
  input  logic [PAIR_BITS-1:0] pairSel,
  input  logic                 wpSwitch,
  output strobes_t             stb
);
  logic anyEn, wordMode, loByte, hiOnly, commonSpace;
  logic evenHit, oddHit, readCyc, writeCyc;
  strobes_t stbNext;

  always_comb begin
    anyEn       = !cardEn1N || !cardEn2N;
    wordMode    = !cardEn1N && !cardEn2N;
    loByte      = !cardEn1N &&  cardEn2N;
    hiOnly      =  cardEn1N && !cardEn2N;
    commonSpace = regSelN;
    evenHit     = wordMode || (loByte && !addr0);
    oddHit      = wordMode || hiOnly || (loByte && addr0);
    readCyc     = anyEn && !outEnN && wrEnN;
    writeCyc    = anyEn && !wrEnN && outEnN && !wpSwitch;
  end

  for (genvar i = 0; i < NUM_SEG; i++) begin : g_seg
    localparam logic [PAIR_BITS-1:0] PAIR_IDX = PAIR_BITS'(i / 2);
    localparam bit IS_ODD = (i % 2) == 1;
    assign stbNext.segCs[i] = commonSpace && (pairSel == PAIR_IDX) &&
                              (IS_ODD ? oddHit : evenHit);
  end

  always_comb begin
    stbNext.attrCs  = !regSelN && anyEn;
    stbNext.wrStb   = writeCyc;
    stbNext.rdStb   = readCyc;
    stbNext.loDrive = readCyc && !cardEn1N;
    stbNext.hiDrive = readCyc && !cardEn2N && commonSpace;
    stbNext.swapLo  = loByte && addr0;
    stbNext.wpFlag  = wpSwitch;
    if (commonSpace)
      stbNext.loSrc = (loByte && addr0) ? LO_ODD : LO_EVEN;
    else
      stbNext.loSrc = (loByte && addr0) ? LO_BAD : LO_ATTR;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stb <= '0;
    else       stb <= stbNext;
  end

  // R10
  seg_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones(stb.segCs) <= 2);

  // R8
  attr_no_seg_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.attrCs |-> (stb.segCs == '0 && !stb.hiDrive));

  // R9
  wp_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    wpSwitch |=> (!stb.wrStb && stb.wpFlag));

  // R5
  standby_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cardEn1N && cardEn2N) |=> (stb.segCs == '0 && !stb.attrCs &&
                                !stb.loDrive && !stb.hiDrive));

  // R6
  oe_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outEnN || !wrEnN) |=> (!stb.loDrive && !stb.hiDrive));

  // R4
  word_two_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!cardEn1N && !cardEn2N && regSelN) |=> ($countones(stb.segCs) == 2));
endmodule

// File: rtl/lane_steer_dp.sv
module lane_steer_dp
  import lane_steer_pkg::*;
(
  input  strobes_t            stb,
  input  logic [WORD_W-1:0]   hostWrData,
  input  logic [BYTE_W-1:0]   evenRdData,
  input  logic [BYTE_W-1:0]   oddRdData,
  input  logic [BYTE_W-1:0]   attrRdData,
  output logic [BYTE_W-1:0]   evenWrData,
  output logic [BYTE_W-1:0]   oddWrData,
  output logic [WORD_W-1:0]   hostRdData
);
  logic [BYTE_W-1:0] loByteSel, hostLo, hostHi;

  assign hostLo = hostWrData[BYTE_W-1:0];
  assign hostHi = hostWrData[WORD_W-1:BYTE_W];

  always_comb begin
    unique case (stb.loSrc)
      LO_EVEN: loByteSel = evenRdData;
      LO_ODD:  loByteSel = oddRdData;
      LO_ATTR: loByteSel = attrRdData;
      default: loByteSel = '1;
    endcase
  end

  always_comb begin
    hostRdData[BYTE_W-1:0]      = stb.loDrive ? loByteSel : '0;
    hostRdData[WORD_W-1:BYTE_W] = stb.hiDrive ? oddRdData : '0;
    evenWrData                  = hostLo;
    oddWrData                   = stb.swapLo ? hostLo : hostHi;
  end
endmodule

// File: rtl/lane_steer_top.sv
module lane_steer_top
  import lane_steer_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cardEn1N,
  input  logic                 cardEn2N,
  input  logic                 outEnN,
  input  logic                 wrEnN,
  input  logic                 regSelN,
  input  logic                 addr0,
  input  logic [PAIR_BITS-1:0] pairSel,
  input  logic                 wpSwitch,
  input  logic [WORD_W-1:0]    hostWrData,
  input  logic [BYTE_W-1:0]    evenRdData,
  input  logic [BYTE_W-1:0]    oddRdData,
  input  logic [BYTE_W-1:0]    attrRdData,
  output logic [NUM_SEG-1:0]   segCs,
  output logic                 attrCs,
  output logic                 memWe,
  output logic                 memOe,
  output logic [BYTE_W-1:0]    evenWrData,
  output logic [BYTE_W-1:0]    oddWrData,
  output logic [WORD_W-1:0]    hostRdData,
  output logic                 loLaneOe,
  output logic                 hiLaneOe,
  output logic                 laneSwap,
  output logic                 wpStatus
);
  strobes_t stb;

  lane_steer_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cardEn1N(cardEn1N), .cardEn2N(cardEn2N),
    .outEnN(outEnN), .wrEnN(wrEnN), .regSelN(regSelN), .addr0(addr0),
    .pairSel(pairSel), .wpSwitch(wpSwitch), .stb(stb)
  );

  lane_steer_dp u_dp (
    .stb(stb), .hostWrData(hostWrData), .evenRdData(evenRdData),
    .oddRdData(oddRdData), .attrRdData(attrRdData),
    .evenWrData(evenWrData), .oddWrData(oddWrData), .hostRdData(hostRdData)
  );

  assign segCs    = stb.segCs;
  assign attrCs   = stb.attrCs;
  assign memWe    = stb.wrStb;
  assign memOe    = stb.rdStb;
  assign loLaneOe = stb.loDrive;
  assign hiLaneOe = stb.hiDrive;
  assign laneSwap = stb.swapLo;
  assign wpStatus = stb.wpFlag;
endmodule

// File: tb/sim_lane_steer_top.sv
module sim_lane_steer_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rstN = 0;
  logic cardEn1N = 1, cardEn2N = 1, outEnN = 1, wrEnN = 1, regSelN = 1;
  logic addr0 = 0, wpSwitch = 0;
  logic [1:0] pairSel = 0;
  logic [15:0] hostWrData = 0;
  logic [7:0] evenRdData = 0, oddRdData = 0, attrRdData = 0;
  logic [7:0] segCs, evenWrData, oddWrData;
  logic [15:0] hostRdData;
  logic attrCs, memWe, memOe, loLaneOe, hiLaneOe, laneSwap, wpStatus;

  int total = 0, bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lane_steer_top u0 (
    .clk(clk), .rstN(rstN), .cardEn1N(cardEn1N), .cardEn2N(cardEn2N),
    .outEnN(outEnN), .wrEnN(wrEnN), .regSelN(regSelN), .addr0(addr0),
    .pairSel(pairSel), .wpSwitch(wpSwitch), .hostWrData(hostWrData),
    .evenRdData(evenRdData), .oddRdData(oddRdData), .attrRdData(attrRdData),
    .segCs(segCs), .attrCs(attrCs), .memWe(memWe), .memOe(memOe),
    .evenWrData(evenWrData), .oddWrData(oddWrData), .hostRdData(hostRdData),
    .loLaneOe(loLaneOe), .hiLaneOe(hiLaneOe), .laneSwap(laneSwap),
    .wpStatus(wpStatus)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++;
    total++;
    summary();
  end

  initial begin
    // R12: reset holds outputs low even with an active request
    cardEn1N = 0; cardEn2N = 0; outEnN = 0; wpSwitch = 1;
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/4);
    chk("R12 segCs", segCs, 0);
    chk("R12 lanes", {loLaneOe, hiLaneOe, memOe, memWe, attrCs}, 0);
    chk("R12 status", {wpStatus, laneSwap}, 0);
    @(negedge clk);
    rstN = 1;

    for (int idx = 0; idx < 512; idx++) begin
      logic e1, e2, oe, we, rg, a0, wp;
      logic [1:0] ps;
      logic anyEn, wordM, loB, hiO, evenH, oddH, rd, wr, loD, hiD, sw;
      logic [7:0] expCs, expLo, expHi, ev, od, at;
      logic [15:0] hw;
      string mtag;
      {e1, e2, oe, we, rg, a0, ps, wp} = idx[8:0];
      ev = 8'h10 + idx[7:0];
      od = 8'hA0 ^ idx[7:0];
      at = 8'h5C ^ idx[7:0];
      hw = {idx[7:0] ^ 8'h3C, idx[7:0] ^ 8'hC3};

      @(negedge clk);
      cardEn1N = e1; cardEn2N = e2; outEnN = oe; wrEnN = we; regSelN = rg;
      addr0 = a0; pairSel = ps; wpSwitch = wp;
      evenRdData = ev; oddRdData = od; attrRdData = at; hostWrData = hw;
      @(posedge clk);
      #(CLK_PERIOD/4);

      anyEn = !e1 || !e2;
      wordM = !e1 && !e2;
      loB = !e1 && e2;
      hiO = e1 && !e2;
      evenH = wordM || (loB && !a0);
      oddH = wordM || hiO || (loB && a0);
      rd = anyEn && !oe && we;
      wr = anyEn && !we && oe && !wp;
      loD = rd && !e1;
      hiD = rd && !e2 && rg;
      sw = loB && a0;
      expCs = 0;
      if (rg) begin
        if (evenH) expCs[2*ps] = 1'b1;
        if (oddH) expCs[2*ps + 1] = 1'b1;
      end
      if (!loD) expLo = 0;
      else if (!rg) expLo = sw ? 8'hFF : at;
      else expLo = sw ? od : ev;
      expHi = hiD ? od : 8'h00;

      if (!anyEn) mtag = "R5";
      else if (!rg) mtag = "R8";
      else if (wordM) mtag = "R4";
      else if (hiO) mtag = "R3";
      else if (a0) mtag = "R2";
      else mtag = "R1";

      chk({"R7 segCs ", mtag}, segCs, expCs);
      chk("R10 count", $countones(segCs), rg ? (wordM ? 2 : (anyEn ? 1 : 0)) : 0);
      chk({"R8 attrCs ", mtag}, attrCs, !rg && anyEn);
      chk("R6 memOe", memOe, rd);
      chk("R9 memWe", memWe, wr);
      chk("R9 wpStatus", wpStatus, wp);
      chk({"R6 laneOe ", mtag}, {loLaneOe, hiLaneOe}, {loD, hiD});
      chk({"R11 rdLo ", mtag}, hostRdData[7:0], expLo);
      chk({"R11 rdHi ", mtag}, hostRdData[15:8], expHi);
      chk("R2 laneSwap", laneSwap, sw);
      chk("R11 evenWr", evenWrData, hw[7:0]);
      chk("R2 oddWr", oddWrData, sw ? hw[7:0] : hw[15:8]);
    end
    summary();
  end
endmodule